// File: doc/BRIEF.md
# Two-Port Access Collision Arbiter

This block sits in front of a two-port memory array and decides, every clock cycle, what happens when both ports are enabled at the same address. The port that presented its address and enable in an earlier cycle keeps the location. The other port sees an active-low busy flag and has its write strobe blocked before it reaches the array. A port "arrives" in the cycle its enable rises or its address changes while enabled. When both ports arrive in the same cycle, the left port wins a fixed tie-break.

A mode pin selects between two roles. In arbitration mode the block makes the decision and drives the busy flags. In follower mode it makes no decision: both busy outputs stay high, and the external busy inputs serve only as write inhibits. Several devices can then share the decision of one arbitrating device. The storage itself and any tri-state data path lie outside this block. The gated write strobes are its output toward the array.

Top module: `dp_collision_arbiter`

## Requirements
- R1: When the two ports are not both enabled at equal addresses in a cycle, both busy outputs are high in the following cycle (arbitration mode).
- R2: The write-enable inputs have no influence on which port wins or on the busy outputs.
- R3: A port that arrived in an earlier cycle wins the collision. The other port's busy output goes low in the cycle after the collision is first seen, and stays low while the collision persists unchanged.
- R4: When both ports arrive in the same cycle at the same address, the left port wins and the right busy output goes low.
- R5: The two busy outputs are never low in the same cycle.
- R6: In the cycle a collision exists, the losing port's write strobe output is held low. The winning port's strobe follows its enable and write-enable.
- R7: In follower mode (`follower_mode`=1), both busy outputs are high one cycle later. A port's write strobe is held low while that port's busy input is low, and follows enable and write-enable otherwise.
- R8: In arbitration mode (`follower_mode`=0), the busy inputs have no effect on the strobes or the busy outputs.
- R9: When the addresses stop matching, or the winner deselects, the blocked port's write strobe passes in that same cycle, and its busy output returns high one cycle later.
- R10: During and right after reset, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| follower_mode | input | 1 | 0 = arbitrate here, 1 = take busy from outside |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in | input | 1 | Left write inhibit in follower mode, active low |
| r_busy_in | input | 1 | Right write inhibit in follower mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| r_busy_n | output | 1 | Right busy flag, active low, registered |
| l_wr_go | output | 1 | Gated left write strobe to the array |
| r_wr_go | output | 1 | Gated right write strobe to the array |

## Verification
The hardest situation to reach is a collision where one port already holds the location and the other port then moves onto it. Random addresses over the full 11-bit range almost never coincide. The stimulus therefore uses directed sequences that stage an early arrival on either side, a same-cycle tie and a release. The random traffic that follows draws addresses from a four-entry window and toggles enables often, so that late arrivals, ties, re-arrivals while enabled and mode switches occur hundreds of times. A behavioural model predicts the strobes and flags on every cycle.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dp_arrival_tracker.sv
// Flags the cycle in which a port newly presents an enabled address.
module dp_arrival_tracker #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  assign fresh = en && (!prev_en || (addr != prev_addr));
endmodule

// File: rtl/dp_priority_resolver.sv
// Decides which port owns a contested location this cycle.
module dp_priority_resolver
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_fresh,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_fresh,
  output logic              clash,
  output owner_e            owner_now
);
  owner_e owner_q;

  assign clash = l_en && r_en && (l_addr == r_addr);

  always_comb begin
    if (!clash)
      owner_now = OWN_NONE;
    else if (owner_q != OWN_NONE && !l_fresh && !r_fresh)
      owner_now = owner_q;              // collision unchanged: keep holder
    else if (l_fresh && !r_fresh)
      owner_now = OWN_RIGHT;            // right was there first
    else
      owner_now = OWN_LEFT;             // left earlier, or tie-break
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_now;
  end
endmodule

// File: rtl/dp_write_gate.sv
// Turns the ownership decision (or external inhibits) into strobes and flags.
module dp_write_gate
  import dp_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   follower_mode,
  input  owner_e owner_now,
  input  logic   l_en,
  input  logic   l_we,
  input  logic   r_en,
  input  logic   r_we,
  input  logic   l_busy_in,
  input  logic   r_busy_in,
  output logic   l_busy_n,
  output logic   r_busy_n,
  output logic   l_wr_go,
  output logic   r_wr_go
);
  logic l_lose, r_lose, l_block, r_block;

  assign l_lose  = (owner_now == OWN_RIGHT);
  assign r_lose  = (owner_now == OWN_LEFT);
  assign l_block = follower_mode ? !l_busy_in : l_lose;
  assign r_block = follower_mode ? !r_busy_in : r_lose;

  assign l_wr_go = l_en && l_we && !l_block;
  assign r_wr_go = r_en && r_we && !r_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_busy_n <= 1'b1;
      r_busy_n <= 1'b1;
    end else begin
      l_busy_n <= follower_mode || !l_lose;
      r_busy_n <= follower_mode || !r_lose;
    end
  end
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              follower_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in,
  input  logic              r_busy_in,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_go,
  output logic              r_wr_go
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]       en_v, fresh_v;
  logic [ADDR_W-1:0]      addr_v [NPORT];
  logic                   clash;
  owner_e                 owner_now;

  assign en_v[0]   = l_en;
  assign en_v[1]   = r_en;
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_track
    dp_arrival_tracker #(.ADDR_W(ADDR_W)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en_v[p]),
      .addr (addr_v[p]),
      .fresh(fresh_v[p])
    );
  end

  dp_priority_resolver #(.ADDR_W(ADDR_W)) u_resolve (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_en     (l_en),
    .l_addr   (l_addr),
    .l_fresh  (fresh_v[0]),
    .r_en     (r_en),
    .r_addr   (r_addr),
    .r_fresh  (fresh_v[1]),
    .clash    (clash),
    .owner_now(owner_now)
  );

  dp_write_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .follower_mode(follower_mode),
    .owner_now    (owner_now),
    .l_en         (l_en),
    .l_we         (l_we),
    .r_en         (r_en),
    .r_we         (r_we),
    .l_busy_in    (l_busy_in),
    .r_busy_in    (r_busy_in),
    .l_busy_n     (l_busy_n),
    .r_busy_n     (r_busy_n),
    .l_wr_go      (l_wr_go),
    .r_wr_go      (r_wr_go)
  );
endmodule

// File: rtl/dp_collision_arbiter_chk.sv
module dp_collision_arbiter_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              follower_mode,
  input logic              l_en,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in,
  input logic              r_busy_in,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_go,
  input logic              r_wr_go
);
  logic same;
  assign same = l_en && r_en && (l_addr == r_addr);

  a_r5_never_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  a_r1_idle_flags_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!follower_mode && !same) |=> (l_busy_n && r_busy_n));

  a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (!follower_mode && same) |-> !(l_wr_go && r_wr_go));

  a_r7_follower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    follower_mode |=> (l_busy_n && r_busy_n));

  a_r7_follower_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (follower_mode && !l_busy_in) |-> !l_wr_go);

  a_r3_late_left_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (!follower_mode && same && !$past(l_en) && $past(r_en) && $stable(r_addr))
    |=> !l_busy_n);
endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_collision_arbiter_test.sv
module dp_collision_arbiter_test;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic follower_mode = 1'b0;
  logic l_en = 1'b0, l_we = 1'b0, r_en = 1'b0, r_we = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in = 1'b1, r_busy_in = 1'b1;
  logic l_busy_n, r_busy_n, l_wr_go, r_wr_go;

  int vectors = 0;
  int misses  = 0;

  // reference state: previous inputs and current holder (0 none, 1 left, 2 right)
  bit m_lpe = 0, m_rpe = 0;
  int m_lpa = 0, m_rpa = 0;
  int m_own = 0;
  bit m_lb = 1, m_rb = 1;

  always #10 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(AW)) uut (.*);

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lpe = 0; m_rpe = 0; m_lpa = 0; m_rpa = 0; m_own = 0; m_lb = 1; m_rb = 1;
  endtask

  // inputs are set right after a negedge; this runs one clock cycle
  task automatic cycle(input string tag);
    bit lf, rf, same, lblk, rblk;
    int own_d;
    #5;
    lf   = l_en && (!m_lpe || int'(l_addr) != m_lpa);
    rf   = r_en && (!m_rpe || int'(r_addr) != m_rpa);
    same = l_en && r_en && (l_addr == r_addr);
    if (!same)                          own_d = 0;
    else if (m_own != 0 && !lf && !rf)  own_d = m_own;
    else if (lf && !rf)                 own_d = 2;
    else                                own_d = 1;
    lblk = follower_mode ? !l_busy_in : (own_d == 2);
    rblk = follower_mode ? !r_busy_in : (own_d == 1);
    chk(tag, "l_wr_go", l_wr_go, l_en && l_we && !lblk);
    chk(tag, "r_wr_go", r_wr_go, r_en && r_we && !rblk);
    m_lb  = follower_mode || own_d != 2;
    m_rb  = follower_mode || own_d != 1;
    m_own = own_d;
    m_lpe = l_en; m_lpa = int'(l_addr);
    m_rpe = r_en; m_rpa = int'(r_addr);
    @(negedge clk);
    chk(tag, "l_busy_n", l_busy_n, m_lb);
    chk(tag, "r_busy_n", r_busy_n, m_rb);
    chk("R5", "both-low", !(l_busy_n === 1'b0 && r_busy_n === 1'b0), 1'b1);
  endtask

  task automatic drive(input bit le, input bit lw, input int la,
                       input bit re, input bit rw, input int ra);
    l_en = le; l_we = lw; l_addr = AW'(la);
    r_en = re; r_we = rw; r_addr = AW'(ra);
  endtask

  initial begin
    #3_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "l_busy_n in reset", l_busy_n, 1'b1);
    chk("R10", "r_busy_n in reset", r_busy_n, 1'b1);
    rst_n = 1'b1;
    model_reset();
    cycle("R10");

    // R1: distinct addresses, both enabled and writing
    drive(1, 1, 12, 1, 1, 13); cycle("R1"); cycle("R1");
    // R3: right holds 0x7FE, left arrives later with a write
    drive(0, 0, 0, 1, 0, 'h7FE); cycle("R3");
    drive(1, 1, 'h7FE, 1, 0, 'h7FE); cycle("R6"); cycle("R3"); cycle("R3");
    // R2: swap read/write roles mid-collision, decision unchanged
    drive(1, 0, 'h7FE, 1, 1, 'h7FE); cycle("R2"); cycle("R2");
    // R9: left moves away, then right released
    drive(1, 1, 'h7FF, 1, 1, 'h7FE); cycle("R9"); cycle("R9");
    // R3 mirror: left holds 5, right arrives writing
    drive(1, 0, 5, 0, 0, 0); cycle("R3");
    drive(1, 0, 5, 1, 1, 5); cycle("R6"); cycle("R3");
    // R9: winner deselects, blocked right writes in the same cycle
    drive(0, 0, 5, 1, 1, 5); cycle("R9"); cycle("R9");
    // R4: both arrive together
    drive(0, 0, 0, 0, 0, 0); cycle("R4");
    drive(1, 1, 9, 1, 1, 9); cycle("R4"); cycle("R4");
    // R8: busy inputs low in arbitration mode do nothing
    drive(1, 1, 20, 1, 1, 21); l_busy_in = 0; r_busy_in = 0; cycle("R8"); cycle("R8");
    // R7: follower mode
    follower_mode = 1; drive(1, 1, 30, 1, 1, 30); cycle("R7"); cycle("R7");
    l_busy_in = 1; cycle("R7");
    r_busy_in = 1; l_busy_in = 0; cycle("R7");
    l_busy_in = 1; follower_mode = 0; drive(0, 0, 0, 0, 0, 0); cycle("R1");

    // random traffic in a narrow address window
    for (int i = 0; i < 4000; i++) begin
      l_en = ($urandom_range(0, 3) != 0);
      r_en = ($urandom_range(0, 3) != 0);
      l_we = $urandom_range(0, 1);
      r_we = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) l_addr = AW'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) r_addr = AW'($urandom_range(0, 3));
      l_busy_in = ($urandom_range(0, 2) != 0);
      r_busy_in = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 49) == 0) follower_mode = ~follower_mode;
      cycle(follower_mode ? "R7" : "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule